// File: doc/BRIEF.md
# Interrupt status aggregation unit

This block collects single-cycle event pulses from the receive path, the transmit path, the bus logic and the PHY of a network interface. Each pulse is kept in a sticky status bit until software reads the status register. The read returns the collected bits and clears them in the same step, so any event that arrives in that same cycle is held for the next read and is not lost. An extra summary bit, computed from the register and never stored, shows whether any of the high-order error bits is set.

Software selects which status bits may raise the interrupt through a mask register, and turns the interrupt on or off through one global enable bit. The single level-sensitive interrupt output is high while the enable is on and at least one masked status bit is set. The register port is a plain read/write strobe interface with one address each for status, mask, enable and a command word. Writing the software-interrupt bit of the command word sets the matching status bit.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the status, mask and enable registers are zero, `irq_o` is low and `reg_rdata` is zero.
- R2: A pulse on `evt_i[b]` at an implemented position sets status bit b at the next clock edge. The bit stays set until a status read. The implemented positions are 0 to 14, 16 and 20 to 25.
- R3: Pulses on `evt_i` at the reserved positions 15, 17, 18 and 19 are ignored. Those bits always read back as zero, except that bit 15 carries the summary bit.
- R4: Bit 15 of a status read value is the OR of status bits 25 down to 16.
- R5: A read strobe at address 0 places the status value, with the summary bit, on `reg_rdata` after the clock edge that takes the strobe. The same edge clears the status register.
- R6: An event pulse in the same cycle as a status read is absent from that read's value and present in the next read's value.
- R7: A write to address 3 with data bit 12 set sets status bit 12 (software interrupt). All other data bits of that write are ignored.
- R8: The mask register is at address 1 and holds bits 25 to 0. The enable register is at address 2 and holds only bit 0. Both read back what was written, with zeros in the bits they do not hold. A write to address 0 has no effect.
- R9: `irq_o` is high exactly when enable bit 0 is set and some bit of the status read value, including summary bit 15, is also set in the mask. It follows the registers in the same cycle.
- R10: A read at any address other than 0 leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 26 | One-cycle event pulses, one per status position |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid after the edge that takes the read strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench pulses each of the 26 event positions alone. For each position it checks the read value, the clear that follows the read, and the interrupt with a mask of that single bit. This separates implemented positions from reserved ones, and shows whether any low bit leaks into the summary. A second set of patterns targets the summary bit with only mask bit 15 set, and sends an event in the same cycle as a read. This shows whether a same-cycle event is dropped, or instead shows up one read early. Further patterns write all-ones to the command, status, mask and enable addresses, which exposes bits that are not masked off. A read of the mask address between an event and a status read shows whether a non-status read clears the status.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int unsigned STAT_W   = 26;
   localparam int unsigned SUM_BIT  = 15;
   localparam int unsigned HI_LO    = 16;
   localparam int unsigned HI_HI    = 25;
   localparam int unsigned SWI_BIT  = 12;

   // implemented event positions: 0..14, 16, 20..25
   function automatic logic [STAT_W-1:0] impl_map();
      logic [STAT_W-1:0] m;
      for (int i = 0; i < int'(STAT_W); i++)
         m[i] = (i <= 14) || (i == 16) || (i >= 20 && i <= 25);
      return m;
   endfunction
endpackage

// File: rtl/irqagg_status_latch.sv
module irqagg_status_latch #(
   parameter int unsigned W = 26,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         clr_i,
   output logic [W-1:0] stat_q
);
   for (genvar b = 0; b < int'(W); b++) begin : g_bit
      if (IMPL[b]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stat_q[b] <= 1'b0;
            else if (clr_i) stat_q[b] <= evt_i[b];
            else            stat_q[b] <= stat_q[b] | evt_i[b];
         end

         p_keep_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[b] |=> stat_q[b]);
         p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[b] && !clr_i) |=> stat_q[b]);
      end else begin : g_rsvd
         assign stat_q[b] = 1'b0;
      end
   end

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && ((evt_i & IMPL) == '0)) |=> (stat_q == '0));
endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary #(
   parameter int unsigned W   = 26,
   parameter int unsigned LO  = 16,
   parameter int unsigned HI  = 25,
   parameter int unsigned SUM = 15
) (
   input  logic [W-1:0] stat_i,
   output logic [W-1:0] view_o
);
   logic any_hi;

   always_comb begin
      any_hi = 1'b0;
      for (int i = int'(LO); i <= int'(HI); i++)
         any_hi = any_hi | stat_i[i];
   end

   always_comb begin
      view_o      = stat_i;
      view_o[SUM] = any_hi;
   end
endmodule

// File: rtl/irqagg_regfile.sv
module irqagg_regfile #(
   parameter int unsigned W         = 26,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned READ_LAT  = 1,
   parameter int unsigned SWI_BIT   = 12,
   parameter logic [ADDR_W-1:0] A_STAT = 0,
   parameter logic [ADDR_W-1:0] A_MASK = 1,
   parameter logic [ADDR_W-1:0] A_EN   = 2,
   parameter logic [ADDR_W-1:0] A_CMD  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [W-1:0]      view_i,
   output logic [W-1:0]      mask_q,
   output logic              en_q,
   output logic [DATA_W-1:0] rdata_o,
   output logic              stat_clr_o,
   output logic              swi_set_o
);
   logic [DATA_W-1:0] rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= 1'b0;
      end else if (wr_i) begin
         if (addr_i == A_MASK) mask_q <= wdata_i[W-1:0];
         if (addr_i == A_EN)   en_q   <= wdata_i[0];
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (addr_i)
         A_STAT:  rd_mux[W-1:0] = view_i;
         A_MASK:  rd_mux[W-1:0] = mask_q;
         A_EN:    rd_mux[0]     = en_q;
         default: rd_mux        = '0;
      endcase
   end

   assign stat_clr_o = rd_i && (addr_i == A_STAT);
   assign swi_set_o  = wr_i && (addr_i == A_CMD) && wdata_i[SWI_BIT];

   if (READ_LAT == 1) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    rdata_q <= '0;
         else if (rd_i) rdata_q <= rd_mux;
      end
      assign rdata_o = rdata_q;

      p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_i |=> $stable(rdata_o));
   end else begin : g_rd_comb
      assign rdata_o = rd_i ? rd_mux : '0;
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int unsigned STAT_W   = irqagg_pkg::STAT_W,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned READ_LAT = 1,
   parameter int unsigned SUM_BIT  = irqagg_pkg::SUM_BIT,
   parameter int unsigned HI_LO    = irqagg_pkg::HI_LO,
   parameter int unsigned HI_HI    = irqagg_pkg::HI_HI,
   parameter int unsigned SWI_BIT  = irqagg_pkg::SWI_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] evt_i,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   localparam logic [STAT_W-1:0] IMPL = irqagg_pkg::impl_map();

   if (HI_HI >= STAT_W || HI_LO > HI_HI) begin : g_bad_range
      $error("summary range out of status width");
   end
   if (DATA_W < STAT_W) begin : g_bad_data
      $error("data width narrower than status");
   end
   if (READ_LAT > 1) begin : g_bad_lat
      $error("read latency must be 0 or 1");
   end
   if (SWI_BIT >= STAT_W || SUM_BIT >= STAT_W) begin : g_bad_pos
      $error("bit position out of status width");
   end

   logic [STAT_W-1:0] stat_q, view, mask_q, evt_all, swi_vec;
   logic              en_q, stat_clr, swi_set;

   always_comb begin
      swi_vec          = '0;
      swi_vec[SWI_BIT] = swi_set;
   end
   assign evt_all = evt_i | swi_vec;

   irqagg_status_latch #(.W(STAT_W), .IMPL(IMPL)) u_latch (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_all), .clr_i(stat_clr), .stat_q(stat_q)
   );

   irqagg_summary #(.W(STAT_W), .LO(HI_LO), .HI(HI_HI), .SUM(SUM_BIT)) u_sum (
      .stat_i(stat_q), .view_o(view)
   );

   irqagg_regfile #(
      .W(STAT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .READ_LAT(READ_LAT), .SWI_BIT(SWI_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd),
      .addr_i(reg_addr), .wdata_i(reg_wdata), .view_i(view),
      .mask_q(mask_q), .en_q(en_q), .rdata_o(reg_rdata),
      .stat_clr_o(stat_clr), .swi_set_o(swi_set)
   );

   assign irq_o = en_q && ((view & mask_q) != '0);

   p_quiet_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);
   p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !irq_o);
   p_cmd_sets_swi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 4'(3) && reg_wdata[SWI_BIT]) |=> stat_q[SWI_BIT]);
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [25:0] evt = '0;
   logic        wr = 0, rd = 0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   irq_aggregator uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr(wr), .reg_rd(rd),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
   );

   function automatic bit is_impl(int i);
      return (i <= 14) || (i == 16) || (i >= 20 && i <= 25);
   endfunction

   function automatic logic [31:0] expect_view(logic [31:0] raw);
      logic [31:0] v = '0;
      for (int i = 0; i < 26; i++) if (raw[i] && is_impl(i)) v[i] = 1'b1;
      if ((v & 32'h03FF_0000) != 0) v[15] = 1'b1;
      return v;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(logic [25:0] v);
      @(negedge clk); evt = v;
      @(negedge clk); evt = '0;
   endtask

   task automatic wreg(logic [3:0] a, logic [31:0] d);
      @(negedge clk); wr = 1; addr = a; wdata = d;
      @(negedge clk); wr = 0;
   endtask

   task automatic rreg(logic [3:0] a, logic [25:0] ev, output logic [31:0] d);
      @(negedge clk); rd = 1; addr = a; evt = ev;
      @(negedge clk); rd = 0; evt = '0;
      d = rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", {31'b0, irq}, 0);
      check("R1 rdata", rdata, 0);
      rreg(4'd0, '0, d); check("R1 status", d, 0);
      rreg(4'd1, '0, d); check("R1 mask", d, 0);
      rreg(4'd2, '0, d); check("R1 enable", d, 0);

      wreg(4'd2, 32'h1);
      // R2 R3 R4 R5 R9 single-bit sweep
      for (int i = 0; i < 26; i++) begin
         logic [31:0] e;
         e = expect_view(32'(1) << i);
         wreg(4'd1, 32'(1) << i);
         pulse(26'(1) << i);
         check($sformatf("R9 irq bit %0d", i), {31'b0, irq}, {31'b0, e[i]});
         pulse('0);
         check($sformatf("R2 sticky bit %0d", i), {31'b0, irq}, {31'b0, e[i]});
         rreg(4'd0, '0, d);
         check($sformatf("R3 R4 read bit %0d", i), d, e);
         check($sformatf("R5 irq clear bit %0d", i), {31'b0, irq}, 0);
         rreg(4'd0, '0, d);
         check($sformatf("R5 cleared bit %0d", i), d, 0);
      end

      // R4 summary through mask bit 15
      wreg(4'd1, 32'h0000_8000);
      pulse(26'h0010_0000);
      check("R4 summary irq", {31'b0, irq}, 1);
      wreg(4'd2, 32'h0);
      check("R9 disabled irq", {31'b0, irq}, 0);
      wreg(4'd2, 32'h1);
      pulse(26'h000F_FFFF & ~26'h0001_0000);
      rreg(4'd0, '0, d);
      check("R4 low bits only", d, expect_view(32'h000F_FFFF & ~32'h0001_0000 | 32'h0010_0000));
      rreg(4'd0, '0, d);
      check("R4 after clear", d, 0);

      // R6 same-cycle event and read
      pulse(26'h1);
      rreg(4'd0, 26'h8, d);
      check("R6 current read", d, 32'h1);
      rreg(4'd0, '0, d);
      check("R6 next read", d, 32'h8);

      // R7 command write
      wreg(4'd3, 32'hFFFF_FFFF);
      rreg(4'd0, '0, d);
      check("R7 swi only", d, 32'h0000_1000);
      wreg(4'd3, 32'hFFFF_EFFF);
      rreg(4'd0, '0, d);
      check("R7 no swi", d, 0);

      // R8 readback and status write ignored
      wreg(4'd1, 32'hFFFF_FFFF);
      rreg(4'd1, '0, d); check("R8 mask", d, 32'h03FF_FFFF);
      wreg(4'd2, 32'hFFFF_FFFE);
      rreg(4'd2, '0, d); check("R8 enable zero", d, 0);
      wreg(4'd2, 32'h0000_FFFF);
      rreg(4'd2, '0, d); check("R8 enable", d, 32'h1);
      wreg(4'd0, 32'hFFFF_FFFF);
      rreg(4'd0, '0, d); check("R8 status write", d, 0);
      check("R8 irq idle", {31'b0, irq}, 0);

      // R10 non-status read keeps status
      pulse(26'h20);
      rreg(4'd1, '0, d);
      rreg(4'd2, '0, d);
      rreg(4'd0, '0, d);
      check("R10 kept", d, 32'h20);

      // R9 mixed mask
      wreg(4'd1, 32'h0000_0040);
      pulse(26'h0000_0080);
      check("R9 unmasked bit", {31'b0, irq}, 0);
      pulse(26'h0000_0040);
      check("R9 masked bit", {31'b0, irq}, 1);
      rreg(4'd0, '0, d);
      check("R9 read both", d, 32'h0000_00C0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule